// File: doc/BRIEF.md
# Gated Beat-Frequency Error Detector

This block measures how fast a beat signal toggles, using the system clock as the time reference, and turns the result into a signed frequency error for a feedback loop. The beat signal is an asynchronous square wave that has already been divided down before it reaches the block. A free-running reference counter defines back-to-back measurement windows of 2^REF_W clock cycles. With the default 16-bit gate on a 50 MHz clock, one window lasts about 1.3 ms. Rising edges of the synchronised beat are counted during each window.

When a window closes, the edge count is latched and subtracted from a target word. The result is a signed error, and a one-cycle strobe marks that the new values are ready. The target comes from external switches. A positive error means the beat is slower than the target, and a negative error means it is faster. The target is captured only at window starts, so a change on the switches applies to the next whole window.

Top module: `beat_err_det`

## Requirements
- R1: While reset is asserted, and until the first report, count_o, err_o and ovf_o are 0 and valid_o is 0.
- R2: Each measurement window lasts exactly 2^REF_W clock cycles. The first window starts at reset release and windows then follow back to back. valid_o goes high once per window, first after the first full window; no strobe appears before that.
- R3: count_o reports the number of rising edges of beat_i counted in the window just closed. beat_i must stay high and low for at least two clock cycles each.
- R4: err_o is a CNT_W+1 bit two's-complement value. It equals the window's target minus count_o, so a negative value means too many edges and a positive value means too few.
- R5: target_i is sampled on the first clock after reset release and at every window boundary. The sampled value is the target for the window that then starts; changes to target_i during a window have no effect on that window's err_o.
- R6: The edge counter saturates at 2^CNT_W-1 instead of wrapping. ovf_o is 1 in the report of a window in which an edge arrived while the counter was full, and 0 in the report of the next window that had no such edge.
- R7: valid_o is high for exactly one clock per report. count_o, err_o and ovf_o change only together with that strobe and hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| beat_i | input | 1 | Asynchronous divided beat square wave |
| target_i | input | CNT_W | Target edge count per window, from switches |
| count_o | output | CNT_W | Latched edge count of the last window |
| err_o | output | CNT_W+1 | Signed error, target minus count |
| ovf_o | output | 1 | Counter overflow seen in the last window |
| valid_o | output | 1 | One-cycle strobe when a new report is out |

## Verification
The assertions assume reset is applied from time zero. They also assume beat_i rises no more often than the synchroniser can resolve, so the edge detector never produces two pulses in a row and each pulse adds at most one count. The bench drives beat_i on falling clock edges, with high and low phases of two cycles each. It places every burst of edges well inside one window, so that the synchroniser delay never moves an edge into a neighbouring window. The bench changes target_i only mid-window, and this checks that the sampled target stays fixed for the whole window.

// File: rtl/beat_err_pkg.sv
package beat_err_pkg;
  localparam int unsigned DEF_REF_W   = 16;
  localparam int unsigned DEF_CNT_W   = 16;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/bed_sync.sv
module bed_sync #(
  parameter int unsigned STAGES = beat_err_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic beat_i,
  output logic rise_o
);
  localparam int unsigned MSB = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], beat_i};
      prev_q <= sync_q[MSB];
    end
  end

  assign rise_o = sync_q[MSB] & ~prev_q;

  // one beat rise must never count twice
  AST_RISE_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R3
endmodule

// File: rtl/bed_gate.sv
module bed_gate #(
  parameter int unsigned REF_W = beat_err_pkg::DEF_REF_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic win_end_o
);
  logic [REF_W-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= '0;
    else         ref_q <= ref_q + 1'b1;
  end

  assign win_end_o = &ref_q;

  AST_GATE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_o |=> (ref_q == '0)); // R2
  AST_GATE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_o |=> !win_end_o); // R2
endmodule

// File: rtl/bed_counter.sv
module bed_counter #(
  parameter int unsigned CNT_W = beat_err_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             ovf_next_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             full;

  assign full       = &cnt_q;
  assign cnt_next_o = (rise_i && !full) ? cnt_q + 1'b1 : cnt_q;
  assign ovf_next_o = ovf_q | (rise_i & full);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_next_o;
      ovf_q <= ovf_next_o;
    end
  end

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !clr_i) |=> (&cnt_q)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i && !clr_i) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/beat_err_det.sv
module beat_err_det #(
  parameter int unsigned REF_W = beat_err_pkg::DEF_REF_W,
  parameter int unsigned CNT_W = beat_err_pkg::DEF_CNT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    beat_i,
  input  logic [CNT_W-1:0]        target_i,
  output logic [CNT_W-1:0]        count_o,
  output logic signed [CNT_W:0]   err_o,
  output logic                    ovf_o,
  output logic                    valid_o
);
  localparam int unsigned ERR_W = CNT_W + 1;

  logic             rise;
  logic             win_end;
  logic [CNT_W-1:0] cnt_next;
  logic             ovf_next;
  logic             armed_q;
  logic [CNT_W-1:0] tgt_q;
  logic signed [ERR_W-1:0] diff;

  bed_sync u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .beat_i(beat_i), .rise_o(rise)
  );

  bed_gate #(.REF_W(REF_W)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_end_o(win_end)
  );

  bed_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .clr_i(win_end),
    .cnt_next_o(cnt_next), .ovf_next_o(ovf_next)
  );

  assign diff = $signed({1'b0, tgt_q}) - $signed({1'b0, cnt_next});

  // target held for a whole window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      tgt_q   <= '0;
    end else if (win_end || !armed_q) begin
      armed_q <= 1'b1;
      tgt_q   <= target_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      err_o   <= '0;
      ovf_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= win_end;
      if (win_end) begin
        count_o <= cnt_next;
        err_o   <= diff;
        ovf_o   <= ovf_next;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R7
  AST_REPORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end |=> ($stable(count_o) && $stable(err_o) && $stable(ovf_o))); // R7
  AST_TGT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !win_end) |=> $stable(tgt_q)); // R5
  AST_ERR_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((err_o < 0) == (count_o > $past(tgt_q)))); // R4
endmodule

// File: tb/beat_err_det_bench.sv
module beat_err_det_bench;
  localparam int unsigned REF_W = 7;
  localparam int unsigned CNT_W = 4;
  localparam int WIN = 1 << REF_W;
  localparam int NV  = 7;
  localparam int V_TGT [NV] = '{10, 12, 3, 15, 0, 7, 15};
  localparam int V_N   [NV] = '{10,  5, 9,  0, 15, 20, 1};
  localparam int V_CNT [NV] = '{10,  5, 9,  0, 15, 15, 1};
  localparam int V_ERR [NV] = '{ 0,  7, -6, 15, -15, -8, 14};
  localparam int V_OVF [NV] = '{ 0,  0, 0,  0,  0,  1, 0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic beat = 1'b0;
  logic [CNT_W-1:0] target = 4'd5;
  logic [CNT_W-1:0] count;
  logic signed [CNT_W:0] err;
  logic ovf, valid;

  int tests = 0, fails = 0, cyc = 0, last_v = 0, period = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  beat_err_det #(.REF_W(REF_W), .CNT_W(CNT_W)) u_beat_err_det (
    .clk_i(clk), .rst_ni(rst_ni), .beat_i(beat), .target_i(target),
    .count_o(count), .err_o(err), .ovf_o(ovf), .valid_o(valid)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!valid);
    period = cyc - last_v;
    last_v = cyc;
  endtask

  task automatic gen_edges(input int n);
    for (int i = 0; i < n; i++) begin
      beat = 1'b1; repeat (2) @(negedge clk);
      beat = 1'b0; repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    int nv;
    repeat (3) @(negedge clk);
    check("R1 count in reset", int'(count), 0);
    check("R1 valid in reset", int'(valid), 0);
    rst_ni = 1'b1;
    nv = 0;
    for (int i = 0; i < WIN - 8; i++) begin
      @(negedge clk);
      if (valid) nv++;
      if (i == 60) target = V_TGT[0];   // mid-window, must not apply yet
    end
    check("R2 no strobe before first window", nv, 0);
    check("R1 err before first report", int'(err), 0);
    check("R1 ovf before first report", int'(ovf), 0);
    wait_valid();
    check("R3 empty first window", int'(count), 0);
    check("R5 target sampled after reset", int'(err), 5);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      check("R7 strobe one cycle", int'(valid), 0);
      @(negedge clk);
      gen_edges(V_N[k]);
      target = (k + 1 < NV) ? V_TGT[k+1] : '0;
      @(negedge clk);
      check("R7 outputs held mid-window", int'(count), (k == 0) ? 0 : V_CNT[k-1]);
      wait_valid();
      check("R2 window length", period, WIN);
      check("R3 edge count", int'(count), V_CNT[k]);
      check("R4 signed error", int'(err), V_ERR[k]);
      check("R6 overflow flag", int'(ovf), V_OVF[k]);
    end

    // directed: async reset mid-window clears reports
    repeat (10) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 count after reset", int'(count), 0);
    check("R1 err after reset", int'(err), 0);
    check("R1 valid after reset", int'(valid), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule